// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a shared, free-running 64-bit main counter that is supplied from outside and raises a one-cycle interrupt pulse when the counter reaches the value held in its comparator. Software programs the channel through 32-bit write strobes that target the configuration word and the low and high halves of the comparator. The configuration, comparator and period registers are presented as read values.

The channel runs in one of two modes. In one-shot mode it fires once per arming. In periodic mode each match adds the stored period to the comparator. If the counter has already moved more than one period past the match point, the channel keeps adding one period per clock, with no further pulses, until the comparator is ahead again. A 32-bit mode confines all comparator arithmetic to the low 32 bits, where "ahead" is decided by the sign of a 32-bit difference. In 32-bit one-shot mode the channel also gives an extra pulse when the low word of the counter wraps. Interrupt routing, the main counter itself and the bus decode are not part of this block.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, `irq_o` is low and `cfg_o` reads 64'h0000_0004_0000_0030 (bits 4 and 5 are the periodic-capable and 64-bit-capable flags, and the upper word is the route capability value 4).
- R2: A configuration write changes only bit 2 (channel enable), bit 3 (periodic), bit 6 (direct comparator load, here called load-through) and bit 8 (32-bit mode). Every other bit, including the level-trigger bit 1, keeps its fixed value.
- R3: A configuration write with bit 8 set clears the upper 32 bits of both the comparator and the period.
- R4: In one-shot mode `irq_o` is high for one cycle in the cycle after the clock edge at which the counter first reaches or passes the comparator, where "passes" means that the signed difference comparator minus counter is not positive. After this the channel stays silent until it is re-armed.
- R5: In periodic mode with a nonzero period, each match produces one pulse and adds the period to the comparator. If the comparator is still not ahead of the counter value seen at the match, one more period is added per clock with no further pulse. With a zero period the channel fires once and holds the comparator.
- R6: In 32-bit mode the comparison uses a 32-bit signed difference, the comparator is advanced modulo 2^32, and the upper halves of the comparator and the period read zero.
- R7: In 32-bit one-shot mode, while armed, a carry of the counter's low word from 0xFFFFFFFF to 0 produces a pulse in addition to the comparator match.
- R8: A low comparator write loads the comparator's low half when the channel is one-shot or load-through is set. In periodic mode the same write also loads the period's low half, with bit 31 forced to zero in 32-bit mode.
- R9: A high comparator write loads the comparator's high half when the channel is one-shot or load-through is set, and otherwise loads the period's high half with bit 63 forced to zero. In 32-bit mode the write changes neither register.
- R10: Load-through (bit 6) clears itself on any comparator write.
- R11: No pulse is issued unless both the channel enable and `glb_en_i` are high.
- R12: Any register write, or a rising `glb_en_i`, re-arms the channel and discards a pending match. `irq_o` is low in the cycle after the re-arming edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CNT_W | Main counter value |
| glb_en_i | input | 1 | Global timer enable |
| cfg_we_i | input | 1 | Write strobe for the configuration word (lower half) |
| cmp_lo_we_i | input | 1 | Write strobe for the comparator low half |
| cmp_hi_we_i | input | 1 | Write strobe for the comparator high half |
| wdata_i | input | CNT_W/2 | Write data |
| cfg_o | output | CNT_W | Configuration read value |
| cmp_o | output | CNT_W | Comparator read value |
| prd_o | output | CNT_W | Period read value |
| irq_o | output | 1 | Edge interrupt pulse |

## Verification
The bench builds the channel with its default parameters: a 64-bit counter and the 32-bit mode generated in. Because the counter is a free input, the bench can jump it straight across the 32-bit wrap point and far beyond a pending comparator. This brings the wrap pulse, modulo-2^32 advance and multi-period catch-up within reach in a few dozen cycles instead of 2^32 ticks.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  // configuration word bit positions (software decodes these)
  localparam int BIT_EN   = 2;
  localparam int BIT_PER  = 3;
  localparam int BIT_PCAP = 4;
  localparam int BIT_WCAP = 5;
  localparam int BIT_LDT  = 6;
  localparam int BIT_M32  = 8;

  typedef struct packed {
    logic m32;
    logic ldt;
    logic per;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/evt_tmr_ahead.sv
// Decides whether value a lies strictly ahead of value b, full width or low half.
module evt_tmr_ahead #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         m32,
  output logic         ahead
);
  localparam int HW = W / 2;

  logic [W-1:0] diff;

  always_comb begin
    diff = a - b;
    if (m32) ahead = !diff[HW-1] && (diff[HW-1:0] != '0);
    else     ahead = !diff[W-1]  && (diff != '0);
  end
endmodule

// File: rtl/evt_tmr_regs.sv
// Configuration, comparator and period storage with the write rules.
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int          W         = 64,
  parameter logic [31:0] ROUTE_CAP = 32'h4,
  parameter bit          SHORT_EN  = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [W/2-1:0]  wdata,
  input  logic            adv,
  output chan_cfg_t       cfg,
  output logic [W-1:0]    cmp,
  output logic [W-1:0]    prd,
  output logic [W-1:0]    step,
  output logic [W-1:0]    cfg_word
);
  localparam int HW = W / 2;

  chan_cfg_t    cfg_q;
  logic [W-1:0] cmp_q;
  logic [W-1:0] prd_q;
  logic [W-1:0] sum;
  logic         load_cmp;
  logic         new_m32;
  logic         cfg_unused;

  assign cfg_unused = ^{wdata[HW-1:BIT_M32+1], wdata[BIT_M32-1], wdata[BIT_WCAP:0]};
  assign load_cmp   = !cfg_q.per || cfg_q.ldt;
  assign sum        = cmp_q + prd_q;

  generate
    if (SHORT_EN) begin : g_short
      assign new_m32 = wdata[BIT_M32];
      assign step    = cfg_q.m32 ? {{HW{1'b0}}, sum[HW-1:0]} : sum;
    end else begin : g_long
      assign new_m32 = 1'b0;
      assign step    = sum;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cmp_q <= '1;
      prd_q <= '0;
    end else if (cfg_we) begin
      cfg_q.en  <= wdata[BIT_EN];
      cfg_q.per <= wdata[BIT_PER];
      cfg_q.ldt <= wdata[BIT_LDT];
      cfg_q.m32 <= new_m32;
      if (new_m32) begin
        cmp_q <= {{HW{1'b0}}, cmp_q[HW-1:0]};
        prd_q <= {{HW{1'b0}}, prd_q[HW-1:0]};
      end
    end else if (lo_we) begin
      if (load_cmp) cmp_q[HW-1:0] <= wdata;
      if (cfg_q.per)
        prd_q[HW-1:0] <= cfg_q.m32 ? {1'b0, wdata[HW-2:0]} : wdata;
      cfg_q.ldt <= 1'b0;
    end else if (hi_we) begin
      if (!cfg_q.m32) begin
        if (load_cmp) cmp_q[W-1:HW] <= wdata;
        else          prd_q[W-1:HW] <= {1'b0, wdata[HW-2:0]};
      end
      cfg_q.ldt <= 1'b0;
    end else if (adv) begin
      cmp_q <= step;
    end
  end

  always_comb begin
    cfg_word           = '0;
    cfg_word[W-1:HW]   = ROUTE_CAP[HW-1:0];
    cfg_word[BIT_EN]   = cfg_q.en;
    cfg_word[BIT_PER]  = cfg_q.per;
    cfg_word[BIT_PCAP] = 1'b1;
    cfg_word[BIT_WCAP] = (W == 64);
    cfg_word[BIT_LDT]  = cfg_q.ldt;
    cfg_word[BIT_M32]  = cfg_q.m32;
  end

  assign cfg = cfg_q;
  assign cmp = cmp_q;
  assign prd = prd_q;
endmodule

// File: rtl/evt_tmr_seq.sv
// Arming, match, catch-up and wrap sequencing; produces the registered pulse.
module evt_tmr_seq
  import evt_tmr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count,
  input  logic         glb_en,
  input  chan_cfg_t    cfg,
  input  logic         prd_nz,
  input  logic         wr_any,
  input  logic         ahead_live,
  input  logic         ahead_next,
  output logic [W-1:0] ref_cnt,
  output logic         adv,
  output logic         irq
);
  localparam int HW = W / 2;

  logic         armed_q, warm_q, catch_q, glb_q, msb_q, irq_q;
  logic [W-1:0] mcnt_q;
  logic         rearm, reached, fire, wrap, step_ok;

  assign rearm   = wr_any || (glb_en && !glb_q);
  assign reached = !ahead_live;
  assign step_ok = cfg.per && prd_nz;
  assign fire    = glb_en && armed_q && !catch_q && reached && !rearm;
  assign wrap    = glb_en && armed_q && warm_q && cfg.m32 && !cfg.per &&
                   msb_q && !count[HW-1] && !rearm;
  assign adv     = !rearm && glb_en &&
                   ((fire && step_ok) || (catch_q && reached));
  assign ref_cnt = catch_q ? mcnt_q : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      warm_q  <= 1'b0;
      catch_q <= 1'b0;
      glb_q   <= 1'b0;
      msb_q   <= 1'b0;
      irq_q   <= 1'b0;
      mcnt_q  <= '0;
    end else begin
      glb_q <= glb_en;
      msb_q <= count[HW-1];
      irq_q <= (fire || wrap) && cfg.en;
      if (rearm) begin
        armed_q <= 1'b1;
        warm_q  <= 1'b1;
        catch_q <= 1'b0;
      end else begin
        if (fire) begin
          if (step_ok) begin
            mcnt_q  <= count;
            catch_q <= !ahead_next;
          end else begin
            armed_q <= 1'b0;
            warm_q  <= 1'b0;
          end
        end
        if (wrap) warm_q <= 1'b0;
        if (catch_q && glb_en && !reached) catch_q <= 1'b0;
      end
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_tmr_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter logic [31:0] ROUTE_CAP = 32'h4,
  parameter bit          SHORT_EN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 glb_en_i,
  input  logic                 cfg_we_i,
  input  logic                 cmp_lo_we_i,
  input  logic                 cmp_hi_we_i,
  input  logic [CNT_W/2-1:0]   wdata_i,
  output logic [CNT_W-1:0]     cfg_o,
  output logic [CNT_W-1:0]     cmp_o,
  output logic [CNT_W-1:0]     prd_o,
  output logic                 irq_o
);
  chan_cfg_t        cfg;
  logic [CNT_W-1:0] cmp, prd, step, ref_cnt;
  logic             adv, ahead_live, ahead_next, wr_any;

  assign wr_any = cfg_we_i || cmp_lo_we_i || cmp_hi_we_i;

  evt_tmr_regs #(.W(CNT_W), .ROUTE_CAP(ROUTE_CAP), .SHORT_EN(SHORT_EN)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we_i), .lo_we(cmp_lo_we_i),
    .hi_we(cmp_hi_we_i), .wdata(wdata_i), .adv(adv), .cfg(cfg),
    .cmp(cmp), .prd(prd), .step(step), .cfg_word(cfg_o)
  );

  evt_tmr_ahead #(.W(CNT_W)) u_live (
    .a(cmp), .b(ref_cnt), .m32(cfg.m32), .ahead(ahead_live)
  );

  evt_tmr_ahead #(.W(CNT_W)) u_next (
    .a(step), .b(count_i), .m32(cfg.m32), .ahead(ahead_next)
  );

  evt_tmr_seq #(.W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .count(count_i), .glb_en(glb_en_i), .cfg(cfg),
    .prd_nz(prd != '0), .wr_any(wr_any), .ahead_live(ahead_live),
    .ahead_next(ahead_next), .ref_cnt(ref_cnt), .adv(adv), .irq(irq_o)
  );

  assign cmp_o = cmp;
  assign prd_o = prd;
endmodule

// File: rtl/evt_timer_chan_chk.sv
module evt_timer_chan_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             cfg_we,
  input logic             cmp_we,
  input logic             wr_m32,
  input logic             en,
  input logic             ldt,
  input logic             m32,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] prd,
  input logic             irq
);
  localparam int HW = CNT_W / 2;

  // R1: reset values
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmp == '1) && (prd == '0) && !irq);

  // R3: setting 32-bit mode clears the upper halves
  p_trunc_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wr_m32) |=> (cmp[CNT_W-1:HW] == '0) && (prd[CNT_W-1:HW] == '0));

  // R6: upper halves stay zero while in 32-bit mode
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    m32 |-> (cmp[CNT_W-1:HW] == '0) && (prd[CNT_W-1:HW] == '0));

  // R9: the period never holds its top bit
  p_prd_top_r9: assert property (@(posedge clk) disable iff (rst)
    !prd[CNT_W-1]);

  // R10: load-through clears after a comparator write
  p_ldt_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !cfg_we) |=> !ldt);

  // R11: a pulse needs both enables
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(glb_en && en));

  // R12: no pulse right after a write
  p_rearm_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (cfg_we || cmp_we) |=> !irq);
endmodule

bind evt_timer_chan evt_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en_i), .cfg_we(cfg_we_i),
  .cmp_we(cmp_lo_we_i || cmp_hi_we_i), .wr_m32(wdata_i[8]),
  .en(cfg_o[2]), .ldt(cfg_o[6]), .m32(cfg_o[8]),
  .cmp(cmp_o), .prd(prd_o), .irq(irq_o)
);

// File: tb/test_evt_timer_chan.sv
`timescale 1ns/1ps
module test_evt_timer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] count = '0;
  logic        glb_en = 1'b0;
  logic        cfg_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [63:0] cfg_o, cmp_o, prd_o;
  logic        irq_o;
  int n_run = 0, n_fail = 0, cyc_n = 0;

  always #2.5 clk = ~clk;

  evt_timer_chan i_evt_timer_chan (
    .clk(clk), .rst(rst), .count_i(count), .glb_en_i(glb_en),
    .cfg_we_i(cfg_we), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we),
    .wdata_i(wdata), .cfg_o(cfg_o), .cmp_o(cmp_o), .prd_o(prd_o),
    .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n == 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc_n);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // kind 0 = configuration, 1 = comparator low, 2 = comparator high
  task automatic wr(input int kind, input logic [31:0] d);
    wdata  = d;
    cfg_we = (kind == 0);
    lo_we  = (kind == 1);
    hi_we  = (kind == 2);
    cyc;
    cfg_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic tick(input logic [63:0] v, input logic exp_irq, input string tag);
    count = v;
    cyc;
    chk(tag, {63'd0, irq_o}, {63'd0, exp_irq});
  endtask

  task automatic t_reset;
    chk("R1 cfg", cfg_o, 64'h0000_0004_0000_0030);
    chk("R1 cmp", cmp_o, '1);
    chk("R1 prd", prd_o, '0);
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_cfg;
    wr(0, 32'hFFFF_FFFF);
    chk("R2 writable bits", cfg_o, 64'h0000_0004_0000_017C);
    chk("R3 cmp truncated", cmp_o, 64'h0000_0000_FFFF_FFFF);
    wr(0, 32'h0);
    chk("R2 cleared", cfg_o, 64'h0000_0004_0000_0030);
  endtask

  task automatic t_oneshot;
    count = 64'd0;
    wr(0, 32'h4);
    wr(1, 32'd100);
    wr(2, 32'd0);
    chk("R4 cmp load", cmp_o, 64'd100);
    glb_en = 1'b1;
    cyc;
    tick(64'd98, 1'b0, "R4 before");
    tick(64'd99, 1'b0, "R4 before");
    tick(64'd100, 1'b1, "R4 match");
    tick(64'd101, 1'b0, "R4 single");
    tick(64'd102, 1'b0, "R4 once");
    wr(1, 32'd200);
    tick(64'd250, 1'b1, "R4 passed");
    tick(64'd260, 1'b0, "R4 passed once");
  endtask

  task automatic t_enable;
    wr(0, 32'h0);
    wr(1, 32'd300);
    tick(64'd300, 1'b0, "R11 chan off");
    tick(64'd301, 1'b0, "R11 chan off");
    wr(0, 32'h4);
    chk("R12 quiet after write", {63'd0, irq_o}, 64'd0);
    cyc;
    chk("R12 fires after rearm", {63'd0, irq_o}, 64'd1);
    glb_en = 1'b0;
    wr(1, 32'd400);
    tick(64'd400, 1'b0, "R11 global off");
    tick(64'd401, 1'b0, "R11 global off");
  endtask

  task automatic t_periodic;
    int pulses;
    wr(0, 32'h4C);
    wr(1, 32'd1010);
    chk("R10 self clear", {63'd0, cfg_o[6]}, 64'd0);
    chk("R8 cmp via ldt", cmp_o, 64'd1010);
    wr(1, 32'd10);
    chk("R8 period only", prd_o, 64'd10);
    chk("R8 cmp held", cmp_o, 64'd1010);
    wr(2, 32'd0);
    count = 64'd1005;
    glb_en = 1'b1;
    cyc;
    tick(64'd1009, 1'b0, "R5 before");
    tick(64'd1010, 1'b1, "R5 match");
    chk("R5 advance", cmp_o, 64'd1020);
    tick(64'd1011, 1'b0, "R5 between");
    tick(64'd1020, 1'b1, "R5 second");
    count = 64'd1075;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      cyc;
      pulses = pulses + int'(irq_o);
    end
    chk("R5 catch-up one pulse", 64'(pulses), 64'd1);
    chk("R5 catch-up cmp", cmp_o, 64'd1080);
    tick(64'd1080, 1'b1, "R5 after catch-up");
    wr(2, 32'hFFFF_FFFF);
    chk("R9 period high", prd_o, 64'h7FFF_FFFF_0000_000A);
    chk("R9 cmp held", cmp_o, 64'd1090);
    wr(2, 32'd0);
    wr(1, 32'd0);
    tick(64'd1090, 1'b1, "R5 zero period fires");
    chk("R5 zero period holds", cmp_o, 64'd1090);
    tick(64'd1091, 1'b0, "R5 zero period once");
    tick(64'd1100, 1'b0, "R5 zero period once");
  endtask

  task automatic t_short_periodic;
    glb_en = 1'b0;
    wr(0, 32'h14C);
    wr(1, 32'hFFFF_FFF0);
    chk("R8 period bit31", prd_o, 64'h0000_0000_7FFF_FFF0);
    wr(1, 32'h20);
    wr(2, 32'h1234);
    chk("R9 ignored cmp", cmp_o, 64'h0000_0000_FFFF_FFF0);
    chk("R9 ignored prd", prd_o, 64'h20);
    count = 64'h5_FFFF_FFEF;
    glb_en = 1'b1;
    cyc;
    tick(64'h5_FFFF_FFF0, 1'b1, "R6 match");
    chk("R6 modular advance", cmp_o, 64'h10);
    tick(64'h6_0000_0010, 1'b1, "R6 across wrap");
    chk("R6 next", cmp_o, 64'h30);
  endtask

  task automatic t_wrap;
    glb_en = 1'b0;
    count = 64'h6_FFFF_FFFE;
    cyc;
    wr(0, 32'h104);
    wr(1, 32'h10);
    glb_en = 1'b1;
    cyc;
    tick(64'h6_FFFF_FFFF, 1'b0, "R7 before wrap");
    tick(64'h7_0000_0000, 1'b1, "R7 wrap pulse");
    tick(64'h7_0000_0001, 1'b0, "R7 after wrap");
    tick(64'h7_0000_0010, 1'b1, "R7 match after wrap");
    tick(64'h7_0000_0020, 1'b0, "R7 done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc;
    t_reset;
    t_cfg;
    t_oneshot;
    t_enable;
    t_periodic;
    t_short_periodic;
    t_wrap;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule